// File: doc/BRIEF.md
# Serial Port Clock/Frame Generator

This block derives every timing signal a synchronous serial port needs from a single system clock. A fixed prescaler, selectable as divide-by-1 or divide-by-8, feeds a programmable prescaler. A final toggle stage turns the result into a serial bit clock with a 50% duty cycle. A bit counter marks each completed word with a one-cycle strobe. A word counter then marks the start of every frame with a frame sync that is one bit period wide.

All derived timing is carried as single-cycle enable strobes in the system clock domain. The bit clock output is a plain register, so no derived clock reaches downstream logic. The divider settings are captured while the block is disabled and again at each frame boundary, so no word or frame is ever cut short. A gated mode lets the bit clock run only while the transmitter reports activity. A separately enabled output passes a copy of the system clock.

Top module: `scg_clock_gen`

## Requirements
- R1: `cfg_wlen_i` selects the number of bit clocks per word: 2'b00 gives 8, 2'b01 gives 10, 2'b10 gives 12 and 2'b11 gives 16. `word_stb_o` is high for one system clock, in the first cycle after the bit clock falls at the end of each word's last bit.
- R2: A frame holds `cfg_frame_div_i`+1 words (1 to 32 at the default width). The word counter moves only when a word completes.
- R3: `frame_sync_o` rises together with the bit clock rising edge of bit 0 of word 0 of each frame, and stays high for exactly one bit period (2H system clocks).
- R4: The half period of the bit clock is H = (`cfg_modulus_i`+1) × (8 when `cfg_range_i`=1, else 1) system clocks. The bit clock period is 2H, with equal high and low phases.
- R5: `bclk_en_o` is high for exactly one system clock: the first cycle in which `bclk_o` is high after having been low.
- R6: With `cfg_gated_i`=1, the bit clock may rise only at a prescaler tick that sees `tx_active_i` high. A started high phase always completes, and `bclk_o` otherwise stays low.
- R7: `sysclk_o` follows the system clock while both `enable_i` and `cfg_sysclk_en_i` are 1, and is low otherwise.
- R8: While `enable_i` is 0, all counters are held at zero and `bclk_o`, `bclk_en_o`, `word_stb_o` and `frame_sync_o` are low from the next clock edge on. After `enable_i` rises, the first bit clock rising edge occurs on the H-th clock edge.
- R9: Range, modulus, word length and frame divider are captured while disabled and at the falling edge that ends the last bit of a frame. A change made mid-frame takes effect from the next frame.
- R10: During and right after reset, all outputs except `sysclk_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the generator; clears it when low |
| cfg_range_i | input | 1 | Fixed prescaler select: 0 = divide by 1, 1 = divide by 8 |
| cfg_modulus_i | input | PM_W (8) | Programmable prescaler divides by this value plus 1 |
| cfg_wlen_i | input | 2 | Word length code |
| cfg_frame_div_i | input | FD_W (5) | Words per frame minus 1 |
| cfg_gated_i | input | 1 | Gated bit clock mode |
| cfg_sysclk_en_i | input | 1 | Enables the system clock copy output |
| tx_active_i | input | 1 | Transfer in progress (used in gated mode) |
| bclk_o | output | 1 | Registered serial bit clock |
| bclk_en_o | output | 1 | One-cycle strobe at each bit start |
| word_stb_o | output | 1 | One-cycle strobe at each word end |
| frame_sync_o | output | 1 | Frame sync, one bit period wide |
| sysclk_o | output | 1 | Gated copy of the system clock |

## Verification
Several relations are checked on every cycle: bit start and word end strobes line up with bit clock edges, the frame sync rises only with a bit start, and the frame counter moves only on completed words. The same checks cover gated idle holding the bit clock low, disable clearing the outputs, and the captured configuration changing only when disabled or at a frame end. Properties that need a whole frame of counting are shown only by the bench's measured frames. These are the exact bit period for each prescaler setting, the number of bits and words per frame, the sync width, first-edge latency after enable, and deferral of a mid-frame configuration change.

// File: rtl/scg_pkg.sv
package scg_pkg;

   localparam int BIT_CNT_W = 5;

   typedef enum logic [1:0] {
      WLEN_8  = 2'b00,
      WLEN_10 = 2'b01,
      WLEN_12 = 2'b10,
      WLEN_16 = 2'b11
   } wlen_e;

   function automatic logic [BIT_CNT_W-1:0] wlen_bits(input wlen_e code);
      logic [BIT_CNT_W-1:0] n;
      case (code)
         WLEN_8:  n = BIT_CNT_W'(8);
         WLEN_10: n = BIT_CNT_W'(10);
         WLEN_12: n = BIT_CNT_W'(12);
         default: n = BIT_CNT_W'(16);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scg_prescaler.sv
module scg_prescaler #(
   parameter int FIX_DIV = 8,
   parameter int PM_W    = 8
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            run_i,
   input  logic            range_i,
   input  logic [PM_W-1:0] modulus_i,
   output logic            half_tick_o
);

   localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
   localparam bit FIX_POW2 = ((FIX_DIV & (FIX_DIV - 1)) == 0);

   logic            fix_tick;
   logic [PM_W-1:0] pre_cnt;

   generate
      if (FIX_DIV < 2) begin : g_bad_div
         $error("scg_prescaler: FIX_DIV must be at least 2");
         assign fix_tick = 1'b1;
      end else if (FIX_POW2) begin : g_fix_pow2
         // power-of-two divider: natural wrap, all-ones detect
         logic [FW-1:0] fix_cnt;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                fix_cnt <= '0;
            else if (!run_i || !range_i) fix_cnt <= '0;
            else                         fix_cnt <= fix_cnt + FW'(1);
         end
         assign fix_tick = !range_i || (&fix_cnt);
      end else begin : g_fix_mod
         localparam logic [FW-1:0] FIX_LAST = FW'(FIX_DIV - 1);
         logic [FW-1:0] fix_cnt;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                 fix_cnt <= '0;
            else if (!run_i || !range_i) fix_cnt <= '0;
            else if (fix_cnt == FIX_LAST) fix_cnt <= '0;
            else                          fix_cnt <= fix_cnt + FW'(1);
         end
         assign fix_tick = !range_i || (fix_cnt == FIX_LAST);
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pre_cnt <= '0;
      else if (!run_i)   pre_cnt <= '0;
      else if (fix_tick) pre_cnt <= (pre_cnt == modulus_i) ? '0 : pre_cnt + PM_W'(1);
   end

   assign half_tick_o = run_i && fix_tick && (pre_cnt == modulus_i);

endmodule

// File: rtl/scg_bitclk.sv
module scg_bitclk (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   input  logic half_tick_i,
   input  logic gated_i,
   input  logic tx_active_i,
   output logic bclk_o,
   output logic bclk_en_o,
   output logic rise_o,
   output logic fall_o,
   output logic skip_o
);

   logic allow;

   assign allow  = !gated_i || tx_active_i;
   assign rise_o = half_tick_i && !bclk_o && allow;
   assign fall_o = half_tick_i && bclk_o;
   assign skip_o = half_tick_i && !bclk_o && !allow;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bclk_o    <= 1'b0;
         bclk_en_o <= 1'b0;
      end else if (!run_i) begin
         bclk_o    <= 1'b0;
         bclk_en_o <= 1'b0;
      end else begin
         if (rise_o)      bclk_o <= 1'b1;
         else if (fall_o) bclk_o <= 1'b0;
         bclk_en_o <= rise_o;
      end
   end

endmodule

// File: rtl/scg_word_frame.sv
module scg_word_frame
   import scg_pkg::*;
#(
   parameter int FD_W = 5
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 run_i,
   input  logic                 rise_i,
   input  logic                 fall_i,
   input  logic                 skip_i,
   input  logic [BIT_CNT_W-1:0] wl_bits_i,
   input  logic [FD_W-1:0]      words_m1_i,
   output logic                 word_stb_o,
   output logic                 frame_sync_o,
   output logic                 frame_done_o,
   output logic [BIT_CNT_W-1:0] bit_cnt_o,
   output logic [FD_W-1:0]      word_cnt_o
);

   logic last_bit, last_word;

   assign last_bit     = (bit_cnt_o == (wl_bits_i - BIT_CNT_W'(1)));
   assign last_word    = (word_cnt_o == words_m1_i);
   assign frame_done_o = fall_i && last_bit && last_word;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         bit_cnt_o  <= '0;
         word_cnt_o <= '0;
         word_stb_o <= 1'b0;
      end else if (!run_i) begin
         bit_cnt_o  <= '0;
         word_cnt_o <= '0;
         word_stb_o <= 1'b0;
      end else begin
         word_stb_o <= fall_i && last_bit;
         if (fall_i) begin
            if (last_bit) begin
               bit_cnt_o  <= '0;
               word_cnt_o <= last_word ? '0 : word_cnt_o + FD_W'(1);
            end else begin
               bit_cnt_o <= bit_cnt_o + BIT_CNT_W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     frame_sync_o <= 1'b0;
      else if (!run_i) frame_sync_o <= 1'b0;
      else if (rise_i) frame_sync_o <= (bit_cnt_o == '0) && (word_cnt_o == '0);
      else if (skip_i) frame_sync_o <= 1'b0;
   end

endmodule

// File: rtl/scg_clock_gen.sv
module scg_clock_gen
   import scg_pkg::*;
#(
   parameter int FIX_DIV = 8,
   parameter int PM_W    = 8,
   parameter int FD_W    = 5
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            enable_i,
   input  logic            cfg_range_i,
   input  logic [PM_W-1:0] cfg_modulus_i,
   input  logic [1:0]      cfg_wlen_i,
   input  logic [FD_W-1:0] cfg_frame_div_i,
   input  logic            cfg_gated_i,
   input  logic            cfg_sysclk_en_i,
   input  logic            tx_active_i,
   output logic            bclk_o,
   output logic            bclk_en_o,
   output logic            word_stb_o,
   output logic            frame_sync_o,
   output logic            sysclk_o
);

   generate
      if (PM_W < 1 || FD_W < 1) begin : g_bad_width
         $error("scg_clock_gen: PM_W and FD_W must be at least 1");
      end
   endgenerate

   // configuration held for the running frame
   logic            act_range_q;
   logic [PM_W-1:0] act_pm_q;
   wlen_e           act_wl_q;
   logic [FD_W-1:0] act_fd_q;

   logic                 half_tick, rise_w, fall_w, skip_w, frame_done_w;
   logic [BIT_CNT_W-1:0] wl_bits_w, bit_cnt_w;
   logic [FD_W-1:0]      word_cnt_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_range_q <= 1'b0;
         act_pm_q    <= '0;
         act_wl_q    <= WLEN_8;
         act_fd_q    <= '0;
      end else if (!enable_i || frame_done_w) begin
         act_range_q <= cfg_range_i;
         act_pm_q    <= cfg_modulus_i;
         act_wl_q    <= wlen_e'(cfg_wlen_i);
         act_fd_q    <= cfg_frame_div_i;
      end
   end

   assign wl_bits_w = wlen_bits(act_wl_q);

   scg_prescaler #(.FIX_DIV(FIX_DIV), .PM_W(PM_W)) u_presc (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (enable_i),
      .range_i     (act_range_q),
      .modulus_i   (act_pm_q),
      .half_tick_o (half_tick)
   );

   scg_bitclk u_bclk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .run_i       (enable_i),
      .half_tick_i (half_tick),
      .gated_i     (cfg_gated_i),
      .tx_active_i (tx_active_i),
      .bclk_o      (bclk_o),
      .bclk_en_o   (bclk_en_o),
      .rise_o      (rise_w),
      .fall_o      (fall_w),
      .skip_o      (skip_w)
   );

   scg_word_frame #(.FD_W(FD_W)) u_wf (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (enable_i),
      .rise_i       (rise_w),
      .fall_i       (fall_w),
      .skip_i       (skip_w),
      .wl_bits_i    (wl_bits_w),
      .words_m1_i   (act_fd_q),
      .word_stb_o   (word_stb_o),
      .frame_sync_o (frame_sync_o),
      .frame_done_o (frame_done_w),
      .bit_cnt_o    (bit_cnt_w),
      .word_cnt_o   (word_cnt_w)
   );

   assign sysclk_o = clk_i && enable_i && cfg_sysclk_en_i;

endmodule

// File: rtl/scg_checker.sv
module scg_checker
   import scg_pkg::*;
#(
   parameter int PM_W = 8,
   parameter int FD_W = 5
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 enable_i,
   input logic                 cfg_gated_i,
   input logic                 tx_active_i,
   input logic                 bclk_o,
   input logic                 bclk_en_o,
   input logic                 word_stb_o,
   input logic                 frame_sync_o,
   input logic [BIT_CNT_W-1:0] bit_cnt,
   input logic [BIT_CNT_W-1:0] wl_bits,
   input logic [FD_W-1:0]      word_cnt,
   input logic [PM_W-1:0]      act_pm,
   input logic                 frame_done
);

   assert_bit_cnt_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_cnt < wl_bits);

   assert_word_stb_on_fall_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_stb_o |-> (!bclk_o && $past(bclk_o)));

   assert_word_cnt_moves_on_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(word_cnt) |-> (word_stb_o || !$past(enable_i)));

   assert_fsync_rises_with_bit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(frame_sync_o) |-> bclk_en_o);

   assert_bclk_en_at_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bclk_en_o |-> (bclk_o && !$past(bclk_o)));

   assert_gated_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_gated_i && !tx_active_i && !bclk_o) |=> !bclk_o);

   assert_disable_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> (!bclk_o && !bclk_en_o && !word_stb_o && !frame_sync_o));

   assert_cfg_at_boundary_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(act_pm) |-> $past(frame_done || !enable_i));

endmodule

bind scg_clock_gen scg_checker #(.PM_W(PM_W), .FD_W(FD_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .enable_i     (enable_i),
   .cfg_gated_i  (cfg_gated_i),
   .tx_active_i  (tx_active_i),
   .bclk_o       (bclk_o),
   .bclk_en_o    (bclk_en_o),
   .word_stb_o   (word_stb_o),
   .frame_sync_o (frame_sync_o),
   .bit_cnt      (bit_cnt_w),
   .wl_bits      (wl_bits_w),
   .word_cnt     (word_cnt_w),
   .act_pm       (act_pm_q),
   .frame_done   (frame_done_w)
);

// File: tb/tb_scg_clock_gen.sv
`timescale 1ns/1ps
module tb_scg_clock_gen;

   logic       clk = 1'b0;
   logic       rst_n, enable, cfg_range, cfg_gated, cfg_sysclk_en, tx_active;
   logic [7:0] cfg_mod;
   logic [1:0] cfg_wlen;
   logic [4:0] cfg_fdiv;
   logic       bclk, bclk_en, word_stb, frame_sync, sysclk;
   logic [7:0] nxt_mod;
   logic [1:0] nxt_wlen;
   logic [4:0] nxt_fdiv;
   int         n_chk = 0, n_bad = 0, cycles = 0;

   always #2 clk = ~clk;

   scg_clock_gen dut (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .cfg_range_i(cfg_range),
      .cfg_modulus_i(cfg_mod), .cfg_wlen_i(cfg_wlen), .cfg_frame_div_i(cfg_fdiv),
      .cfg_gated_i(cfg_gated), .cfg_sysclk_en_i(cfg_sysclk_en), .tx_active_i(tx_active),
      .bclk_o(bclk), .bclk_en_o(bclk_en), .word_stb_o(word_stb),
      .frame_sync_o(frame_sync), .sysclk_o(sysclk)
   );

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 195000) begin
         n_bad++;
         $display("FAIL watchdog (all R): actual=%0d cycles expected below %0d", cycles, 195000);
         summary();
         $finish;
      end
   end

   task automatic check_eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_half(input int psr, input int pm);
      return (pm + 1) * (psr != 0 ? 8 : 1);
   endfunction

   function automatic int exp_wbits(input int wl);
      case (wl)
         0:       return 8;
         1:       return 10;
         2:       return 12;
         default: return 16;
      endcase
   endfunction

   task automatic restart(input int psr, input int pm, input int wl, input int dc);
      @(negedge clk);
      enable    = 1'b0;
      cfg_range = psr[0];
      cfg_mod   = pm[7:0];
      cfg_wlen  = wl[1:0];
      cfg_fdiv  = dc[4:0];
      @(negedge clk);
      enable = 1'b1;
   endtask

   // measures one frame from its sync rise to the next sync rise
   task automatic measure_frame(input int change_after, input bit at_start,
                                output int bits, output int per, output int uniform,
                                output int words, output int fsw, output int en_err,
                                output int stb_err);
      int   cyc, last, d;
      logic pb, pf, rise;
      cyc = 0; bits = 1; per = 0; uniform = 1; words = 0; fsw = 1; en_err = 0; stb_err = 0;
      if (!at_start) begin
         pf = frame_sync;
         forever begin
            @(negedge clk);
            cyc++;
            if (frame_sync && !pf) break;
            pf = frame_sync;
            if (cyc > 150000) break;
         end
      end
      last = cyc; pb = 1'b1; pf = 1'b1;
      forever begin
         @(negedge clk);
         cyc++;
         rise = bclk && !pb;
         if (bclk_en != rise) en_err++;
         if (word_stb) begin
            words++;
            if (!(!bclk && pb)) stb_err++;
         end
         if (rise && frame_sync && !pf) break;
         if (frame_sync) fsw++;
         if (rise) begin
            d = cyc - last;
            last = cyc;
            if (per == 0) per = d;
            else if (d != per) uniform = 0;
            bits++;
            if (bits == change_after) begin
               cfg_mod = nxt_mod; cfg_wlen = nxt_wlen; cfg_fdiv = nxt_fdiv;
            end
         end
         pb = bclk; pf = frame_sync;
         if (cyc > 150000) break;
      end
   endtask

   task automatic check_frame(input int psr, input int pm, input int wl, input int dc,
                              input int bits, input int per, input int uniform,
                              input int words, input int fsw, input int en_err,
                              input int stb_err);
      int h;
      h = exp_half(psr, pm);
      check_eq("R1", "bits per frame", bits, exp_wbits(wl) * (dc + 1));
      check_eq("R1", "word strobe misplaced", stb_err, 0);
      check_eq("R2", "words per frame", words, dc + 1);
      check_eq("R3", "frame sync width", fsw, 2 * h);
      check_eq("R4", "bit period", per, 2 * h);
      check_eq("R4", "period uniform", uniform, 1);
      check_eq("R5", "bit enable strobe errors", en_err, 0);
   endtask

   task automatic run_cfg(input int psr, input int pm, input int wl, input int dc);
      int b, p, u, w, f, e, s;
      restart(psr, pm, wl, dc);
      measure_frame(0, 1'b0, b, p, u, w, f, e, s);
      check_frame(psr, pm, wl, dc, b, p, u, w, f, e, s);
   endtask

   initial begin
      int b, p, u, w, f, e, s, k, hi_cnt, seed_v;
      seed_v = $urandom(32'd20517);
      rst_n = 1'b0; enable = 1'b0; cfg_range = 1'b0; cfg_mod = '0; cfg_wlen = '0;
      cfg_fdiv = '0; cfg_gated = 1'b0; cfg_sysclk_en = 1'b1; tx_active = 1'b0;
      nxt_mod = '0; nxt_wlen = '0; nxt_fdiv = '0;
      repeat (4) @(negedge clk);
      check_eq("R10", "outputs in reset", {28'd0, bclk, bclk_en, word_stb, frame_sync}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R10", "outputs after reset", {28'd0, bclk, bclk_en, word_stb, frame_sync}, 0);
      @(posedge clk); #1;
      check_eq("R7", "sysclk while disabled", int'(sysclk), 0);

      // first edge latency: H = 3*8 = 24
      restart(1, 2, 0, 0);
      k = 0;
      do begin @(negedge clk); k++; end while (!bclk && k < 10000);
      check_eq("R8", "edges to first rise", k, 24);
      @(posedge clk); #1;
      check_eq("R7", "sysclk high phase when enabled", int'(sysclk), 1);
      @(negedge clk);
      check_eq("R7", "sysclk low phase", int'(sysclk), 0);
      cfg_sysclk_en = 1'b0;
      @(posedge clk); #1;
      check_eq("R7", "sysclk with its enable off", int'(sysclk), 0);
      cfg_sysclk_en = 1'b1;

      // disable while bit clock high
      do @(negedge clk); while (!bclk);
      enable = 1'b0;
      @(negedge clk);
      check_eq("R8", "outputs after disable", {28'd0, bclk, bclk_en, word_stb, frame_sync}, 0);

      // directed corners
      run_cfg(0, 0, 0, 0);
      run_cfg(0, 0, 3, 31);
      run_cfg(1, 255, 0, 0);
      run_cfg(0, 4, 1, 2);
      run_cfg(1, 0, 2, 1);

      // random configurations
      for (int i = 0; i < 8; i++) begin
         int rp, rm, rw, rd;
         rp = int'($urandom % 2);
         rm = (rp != 0) ? int'($urandom % 3) : int'($urandom % 8);
         rw = int'($urandom % 4);
         rd = int'($urandom % 8);
         run_cfg(rp, rm, rw, rd);
      end

      // mid-frame configuration change
      nxt_mod = 8'd3; nxt_wlen = 2'd1; nxt_fdiv = 5'd1;
      restart(0, 1, 0, 3);
      measure_frame(5, 1'b0, b, p, u, w, f, e, s);
      check_eq("R9", "frame with change keeps bits", b, 32);
      check_eq("R9", "frame with change keeps period", p, 4);
      check_eq("R9", "frame with change keeps words", w, 4);
      measure_frame(0, 1'b1, b, p, u, w, f, e, s);
      check_eq("R9", "next frame bits", b, 20);
      check_eq("R9", "next frame period", p, 8);
      check_eq("R9", "next frame words", w, 2);
      check_eq("R3", "next frame sync width", f, 8);

      // gated mode, H = 3
      cfg_gated = 1'b1; tx_active = 1'b0;
      restart(0, 2, 0, 0);
      hi_cnt = 0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (bclk || frame_sync) hi_cnt++;
      end
      check_eq("R6", "gated idle high samples", hi_cnt, 0);
      tx_active = 1'b1;
      k = 0;
      do begin @(negedge clk); k++; end while (!bclk && k < 100);
      check_eq("R6", "resume within H", int'(k >= 1 && k <= 3), 1);
      repeat (30) @(negedge clk);
      tx_active = 1'b0;
      repeat (7) @(negedge clk);
      hi_cnt = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (bclk) hi_cnt++;
      end
      check_eq("R6", "gated stop high samples", hi_cnt, 0);
      enable = 1'b0; cfg_gated = 1'b0;
      @(negedge clk);

      summary();
      $finish;
   end

endmodule